// File: doc/BRIEF.md
# Sequential Trapping Integer Divider

This block divides a double-width dividend by a single-width divisor over many clock cycles, one quotient bit per cycle. The dividend arrives as two single-width halves, upper and lower. A mode input picks unsigned or two's-complement signed division. The block returns a single-width quotient and remainder. When the divisor is zero, or the true quotient cannot be represented in single width, it raises a fault instead of returning a result.

A request is accepted by raising `start` while the block is idle. The operands are sampled on that edge. Signed operands are first turned into magnitudes: the dividend is negated across its full double width. An unsigned shift-subtract loop then runs for exactly `W` iterations. Afterwards the signs are restored and the signed range is checked. Some faults can be found before the loop starts: a zero divisor, or an upper dividend half at least as large as the divisor. These are reported on the cycle after acceptance, without iterating.

`done` marks the single cycle in which the outcome is presented. The quotient and remainder outputs change only on a successful completion.

Top module: `seqdiv_trap`

## Requirements
- R1: A zero divisor, in either mode, makes `done` and `fault` both high in the cycle after acceptance. The loop does not run, and `quotient`/`remainder` are not updated.
- R2: In unsigned mode, when `dvd_hi >= divisor` the operation faults in the cycle after acceptance, without iterating.
- R3: In unsigned mode, when `dvd_hi < divisor`, `quotient` = floor({dvd_hi,dvd_lo} / divisor) and `remainder` = {dvd_hi,dvd_lo} mod divisor.
- R4: When the upper dividend half is zero, the result is `dvd_lo / divisor` with remainder `dvd_lo mod divisor`.
- R5: In signed mode (`signed_op`=1, operands in two's complement), the quotient is the exact quotient truncated toward zero. The remainder is zero or carries the sign of the dividend.
- R6: In signed mode, when the operand signs differ, a quotient magnitude up to and including 2^(W-1) is accepted and returned negated. When the signs match, a quotient magnitude of 2^(W-1) or more faults.
- R7: In signed mode, when the upper half of the dividend magnitude is at least the divisor magnitude, the operation faults in the cycle after acceptance.
- R8: A non-early completion raises `done` W+1 rising edges after the accepting edge, counting that edge. `done` is high for exactly one cycle per operation.
- R9: `busy` is high from acceptance until completion. `start` is ignored while `busy` is high: the running operation's result and timing are unaffected, and no extra `done` follows.
- R10: When `fault` is reported, `quotient` and `remainder` keep the values they held before.
- R11: After reset, `busy`, `done` and `fault` are 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted when the block is idle |
| signed_op | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dvd_hi | input | W | Upper half of the dividend |
| dvd_lo | input | W | Lower half of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | An operation is iterating |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Valid with `done`: divide by zero or quotient overflow |
| quotient | output | W | Last successful quotient |
| remainder | output | W | Last successful remainder |

## Verification
The bench targets the edges of the signed range:
- A quotient of exactly -2^(W-1) must pass. A design using one symmetric limit would trap it.
- A positive quotient of 2^(W-1) must trap. A design with the limit off by one would return a negative number.
- An upper half equal to the divisor must trap early. A design using `>` would instead iterate and return a truncated quotient.

The bench also covers:
- All four sign combinations. Here a design that negates only the lower dividend half, or gives the remainder the divisor's sign, returns visibly wrong values.
- A second `start` during an operation, whose divisor of zero would trap if it were taken.
- Outputs after a fault. A design that writes garbage on a trap changes them.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  typedef enum logic {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } dv_state_e;
endpackage

// File: rtl/seqdiv_prep.sv
// Operand conditioning: sign-magnitude conversion and the checks that can
// be decided before iterating.
module seqdiv_prep #(
  parameter int W = 64
) (
  input  logic         sgn,
  input  logic [W-1:0] in_hi,
  input  logic [W-1:0] in_lo,
  input  logic [W-1:0] in_den,
  output logic [W-1:0] mag_hi,
  output logic [W-1:0] mag_lo,
  output logic [W-1:0] mag_den,
  output logic         neg_num,
  output logic         neg_den,
  output logic         div_zero,
  output logic         early_ovf
);
  localparam int DW = 2 * W;

  function automatic logic [DW-1:0] twos_neg_wide(input logic [DW-1:0] v);
    return (~v) + DW'(1);
  endfunction

  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] v);
    return (~v) + W'(1);
  endfunction

  logic [DW-1:0] num_raw;
  logic [DW-1:0] num_mag;

  always_comb begin
    num_raw   = {in_hi, in_lo};
    neg_num   = sgn & in_hi[W-1];
    neg_den   = sgn & in_den[W-1];
    num_mag   = neg_num ? twos_neg_wide(num_raw) : num_raw;
    mag_hi    = num_mag[DW-1:W];
    mag_lo    = num_mag[W-1:0];
    mag_den   = neg_den ? twos_neg(in_den) : in_den;
    div_zero  = (in_den == '0);
    // quotient needs more than W bits when the upper half reaches the divisor
    early_ovf = (mag_hi >= mag_den);
  end
endmodule

// File: rtl/seqdiv_step.sv
// One restoring shift-subtract iteration on the partial-remainder/quotient pair.
module seqdiv_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] part_hi,
  input  logic [W-1:0] part_lo,
  input  logic [W-1:0] den,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  function automatic logic take_bit(input logic carry_out,
                                    input logic [W-1:0] shifted,
                                    input logic [W-1:0] d);
    // a bit lost off the top means the true remainder exceeds any W-bit divisor
    return carry_out || (shifted >= d);
  endfunction

  logic         spill;
  logic [W-1:0] shifted;
  logic         qbit;

  always_comb begin
    spill   = part_hi[W-1];
    shifted = {part_hi[W-2:0], part_lo[W-1]};
    qbit    = take_bit(spill, shifted, den);
    nxt_hi  = qbit ? (shifted - den) : shifted;
    nxt_lo  = {part_lo[W-2:0], qbit};
  end
endmodule

// File: rtl/seqdiv_post.sv
// Sign restoration and the signed range check on the final magnitudes.
module seqdiv_post #(
  parameter int W = 64
) (
  input  logic         sgn,
  input  logic         neg_num,
  input  logic         neg_den,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out,
  output logic         range_ovf
);
  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] v);
    return (~v) + W'(1);
  endfunction

  // negative results may reach 2^(W-1); positive ones must stay below it
  function automatic logic out_of_range(input logic opposite,
                                        input logic [W-1:0] m);
    logic at_or_above_half;
    logic above_half;
    at_or_above_half = m[W-1];
    above_half       = m[W-1] && (m[W-2:0] != '0);
    return opposite ? above_half : at_or_above_half;
  endfunction

  logic opposite;

  always_comb begin
    opposite = neg_num ^ neg_den;
    if (sgn) begin
      range_ovf = out_of_range(opposite, quo_mag);
      quo_out   = opposite ? twos_neg(quo_mag) : quo_mag;
      rem_out   = neg_num ? twos_neg(rem_mag) : rem_mag;
    end else begin
      range_ovf = 1'b0;
      quo_out   = quo_mag;
      rem_out   = rem_mag;
    end
  end
endmodule

// File: rtl/seqdiv_trap.sv
module seqdiv_trap
  import seqdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_op,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int          CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  dv_state_e     state;
  logic [CW-1:0] iter_cnt;
  logic [W-1:0]  acc_hi, acc_lo, den_r;
  logic          sgn_r, nnum_r, nden_r;
  logic [W-1:0]  quo_r, rem_r;
  logic          done_r, fault_r;

  // conditioning of the incoming operands
  logic [W-1:0] p_hi, p_lo, p_den;
  logic         p_nnum, p_nden, p_zero, p_ovf;

  seqdiv_prep #(.W(W)) u_prep (
    .sgn      (signed_op),
    .in_hi    (dvd_hi),
    .in_lo    (dvd_lo),
    .in_den   (divisor),
    .mag_hi   (p_hi),
    .mag_lo   (p_lo),
    .mag_den  (p_den),
    .neg_num  (p_nnum),
    .neg_den  (p_nden),
    .div_zero (p_zero),
    .early_ovf(p_ovf)
  );

  // iteration datapath
  logic [W-1:0] s_hi, s_lo;

  seqdiv_step #(.W(W)) u_step (
    .part_hi(acc_hi),
    .part_lo(acc_lo),
    .den    (den_r),
    .nxt_hi (s_hi),
    .nxt_lo (s_lo)
  );

  // final sign fix, fed by the last iteration directly
  logic [W-1:0] f_quo, f_rem;
  logic         f_ovf;

  seqdiv_post #(.W(W)) u_post (
    .sgn      (sgn_r),
    .neg_num  (nnum_r),
    .neg_den  (nden_r),
    .quo_mag  (s_lo),
    .rem_mag  (s_hi),
    .quo_out  (f_quo),
    .rem_out  (f_rem),
    .range_ovf(f_ovf)
  );

  // named internal events
  logic start_acc;
  logic early_trap;
  logic last_iter;

  assign start_acc  = start && (state == DV_IDLE);
  assign early_trap = start_acc && (p_zero || p_ovf);
  assign last_iter  = (state == DV_RUN) && (iter_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= DV_IDLE;
      iter_cnt <= '0;
      acc_hi   <= '0;
      acc_lo   <= '0;
      den_r    <= '0;
      sgn_r    <= 1'b0;
      nnum_r   <= 1'b0;
      nden_r   <= 1'b0;
      quo_r    <= '0;
      rem_r    <= '0;
      done_r   <= 1'b0;
      fault_r  <= 1'b0;
    end else begin
      done_r  <= 1'b0;
      fault_r <= 1'b0;
      unique case (state)
        DV_IDLE: begin
          if (early_trap) begin
            done_r  <= 1'b1;
            fault_r <= 1'b1;
          end else if (start_acc) begin
            state    <= DV_RUN;
            iter_cnt <= '0;
            acc_hi   <= p_hi;
            acc_lo   <= p_lo;
            den_r    <= p_den;
            sgn_r    <= signed_op;
            nnum_r   <= p_nnum;
            nden_r   <= p_nden;
          end
        end
        DV_RUN: begin
          acc_hi   <= s_hi;
          acc_lo   <= s_lo;
          iter_cnt <= iter_cnt + CW'(1);
          if (last_iter) begin
            state  <= DV_IDLE;
            done_r <= 1'b1;
            if (f_ovf) begin
              fault_r <= 1'b1;
            end else begin
              quo_r <= f_quo;
              rem_r <= f_rem;
            end
          end
        end
        default: state <= DV_IDLE;
      endcase
    end
  end

  assign busy      = (state == DV_RUN);
  assign done      = done_r;
  assign fault     = fault_r;
  assign quotient  = quo_r;
  assign remainder = rem_r;

  // R1: a zero divisor traps on the next cycle
  assert_zero_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && (divisor == '0) |=> done && fault);

  // R2: unsigned upper half at or above the divisor traps without iterating
  assert_early_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && !signed_op && (dvd_hi >= divisor) |=> done && fault && !busy);

  // R3: partial remainder stays below the divisor during the loop
  assert_part_rem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc_hi < den_r));

  // R8: completion strobe lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a running operation keeps its divisor whatever start does
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_iter |=> busy && $stable(den_r) && $stable(sgn_r));

  // R10: result outputs are untouched by a trap
  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done && $stable(quotient) && $stable(remainder));
endmodule

// File: tb/tb_seqdiv_trap.sv
module tb_seqdiv_trap;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         signed_op = 1'b0;
  logic [W-1:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic         busy, done, fault;
  logic [W-1:0] quotient, remainder;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] last_q = '0, last_r = '0;

  always #5 clk = ~clk;

  seqdiv_trap #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_op(signed_op),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .busy(busy), .done(done), .fault(fault),
    .quotient(quotient), .remainder(remainder)
  );

  typedef struct packed {
    logic         f;
    logic         early;
    logic [W-1:0] q;
    logic [W-1:0] r;
  } exp_t;

  // reference computed with full double-width arithmetic
  function automatic exp_t ref_div(input logic [W-1:0] h, l, d, input logic s);
    exp_t e;
    logic [2*W-1:0] n, nm, qm, rm;
    logic [W-1:0] dm;
    logic sa, sb;
    e  = '0;
    n  = {h, l};
    sa = s && h[W-1];
    sb = s && d[W-1];
    nm = sa ? (~n + 1'b1) : n;
    dm = sb ? (~d + 1'b1) : d;
    if (d == '0) begin
      e.f = 1'b1; e.early = 1'b1;
      return e;
    end
    qm = nm / {{W{1'b0}}, dm};
    rm = nm % {{W{1'b0}}, dm};
    if (qm[2*W-1:W] != '0) begin
      e.f = 1'b1; e.early = 1'b1;
      return e;
    end
    if (!s) begin
      e.q = qm[W-1:0];
      e.r = rm[W-1:0];
    end else begin
      if (sa != sb) begin
        if (qm[W-1:0] > {1'b1, {(W-1){1'b0}}}) e.f = 1'b1;
        e.q = ~qm[W-1:0] + 1'b1;
      end else begin
        if (qm[W-1]) e.f = 1'b1;
        e.q = qm[W-1:0];
      end
      e.r = sa ? (~rm[W-1:0] + 1'b1) : rm[W-1:0];
    end
    return e;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [W-1:0] h, l, d, input logic s, input string req);
    exp_t e;
    int   lat;
    e = ref_div(h, l, d, s);
    @(negedge clk);
    dvd_hi = h; dvd_lo = l; divisor = d; signed_op = s; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(posedge clk); #1;
      lat++;
    end
    chk(done, req, "done seen", W'(done), W'(1));
    chk(fault == e.f, req, "fault", W'(fault), W'(e.f));
    chk(lat == (e.early ? 1 : W + 1), "R8", "latency", W'(lat), W'(e.early ? 1 : W + 1));
    if (e.f) begin
      chk(quotient == last_q, "R10", "quotient held", quotient, last_q);
      chk(remainder == last_r, "R10", "remainder held", remainder, last_r);
    end else begin
      chk(quotient == e.q, req, "quotient", quotient, e.q);
      chk(remainder == e.r, req, "remainder", remainder, e.r);
      last_q = e.q;
      last_r = e.r;
    end
    @(posedge clk); #1;
    chk(!done, "R8", "done one cycle", W'(done), W'(0));
  endtask

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] h, l, d;
    logic [2*W-1:0] n, q128, d128, r128;
    int   lat;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(!busy && !done && !fault, "R11", "flags", {61'd0, busy, done, fault}, '0);
    chk(quotient == '0, "R11", "quotient", quotient, '0);
    chk(remainder == '0, "R11", "remainder", remainder, '0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    run_op(64'd0, 64'd100, 64'd7, 1'b0, "R4");
    run_op(64'd0, ONES, 64'd3, 1'b0, "R4");
    run_op(64'd5, 64'd9, 64'd0, 1'b0, "R1");
    run_op(ONES, 64'd9, 64'd0, 1'b1, "R1");
    run_op(64'd7, 64'd0, 64'd7, 1'b0, "R2");
    run_op(64'd9, 64'd1, 64'd7, 1'b0, "R2");
    run_op(ONES - 1, ONES, ONES, 1'b0, "R3");
    run_op(64'h123, 64'h4567_89ab_cdef_0123, 64'h1_0000_0000, 1'b0, "R3");
    run_op(ONES, -64'sd7, 64'd2, 1'b1, "R5");
    run_op(64'd0, 64'd7, -64'sd2, 1'b1, "R5");
    run_op(ONES, -64'sd7, -64'sd2, 1'b1, "R5");
    run_op(64'd0, 64'd7, 64'd2, 1'b1, "R5");
    run_op(ONES, HALF, 64'd1, 1'b1, "R6");
    run_op(64'd0, HALF, 64'd1, 1'b1, "R6");
    run_op(ONES, HALF, ONES, 1'b1, "R6");
    run_op(64'd0, HALF - 1, 64'd1, 1'b1, "R6");
    run_op(64'd1, 64'd0, 64'd1, 1'b1, "R7");
    run_op(-64'sd3, 64'd0, -64'sd3, 1'b1, "R7");

    // R9: second start during a running operation is dropped
    @(negedge clk);
    dvd_hi = 64'd0; dvd_lo = 64'd1000; divisor = 64'd9; signed_op = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy, "R9", "busy after accept", W'(busy), W'(1));
    repeat (5) @(posedge clk);
    @(negedge clk);
    dvd_lo = 64'd5; divisor = 64'd0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!done, "R9", "no trap from ignored start", W'(done), W'(0));
    lat = 7;
    while (!done && lat < 200) begin
      @(posedge clk); #1;
      lat++;
    end
    chk(lat == W + 1, "R9", "latency unchanged", W'(lat), W'(W + 1));
    chk(!fault && quotient == 64'd111, "R9", "quotient", quotient, 64'd111);
    chk(remainder == 64'd1, "R9", "remainder", remainder, 64'd1);
    last_q = 64'd111; last_r = 64'd1;
    repeat (3) begin
      @(posedge clk); #1;
      chk(!done && !busy, "R9", "no extra done", W'(done), W'(0));
    end

    // random unsigned
    for (int i = 0; i < 120; i++) begin
      d = {$urandom, $urandom} >> ($urandom % 64);
      l = {$urandom, $urandom};
      h = (d == '0) ? '0 : ({$urandom, $urandom} % d);
      if (i % 10 == 0) h = {$urandom, $urandom};
      run_op(h, l, d, 1'b0, (h == '0) ? "R4" : "R3");
    end
    // random signed, built as quotient*divisor + remainder
    for (int i = 0; i < 120; i++) begin
      q128 = {{(2*W-32){1'b0}}, $urandom} << ($urandom % 40);
      if ($urandom % 2) q128 = ~q128 + 1'b1;
      d128 = {{W{1'b0}}, {$urandom, $urandom} >> ($urandom % 63)};
      if ($urandom % 2) d128 = ~d128 + 1'b1;
      r128 = {{(2*W-16){1'b0}}, 16'($urandom)};
      if ($urandom % 2) r128 = ~r128 + 1'b1;
      n = q128 * d128 + r128;
      run_op(n[2*W-1:W], n[W-1:0], d128[W-1:0], 1'b1, (i % 2) ? "R5" : "R6");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule